// File: doc/BRIEF.md
# Gated UART Configuration Register Bank

This block holds the programming registers of a bus-to-UART bridge that follows the classic 16750-style register model. A host reaches it through a plain register port: a 3-bit address, write data, a write strobe and a read strobe. Its outputs are the decoded configuration fields that the serial engine, the FIFOs and the baud generator use. It also drives two one-cycle flush pulses for the FIFOs.

Each address can reach more than one register. Which one it reaches depends on state held inside the bank:
- With line-control bit 7 set, addresses 0 and 1 reach the baud divisor.
- A special line-control value opens the enhanced feature register at address 2.
- The enhanced-enable bit of that register unlocks some bits in the FIFO-control and modem-control registers.
- The enhanced-enable bit together with the modem-control tuning bit exposes the flow-threshold and trigger-level registers at addresses 6 and 7.

Software initialises the bridge by stepping through this state: first set the divisor, then the line format, then the enhanced features, then the tuning registers.

Top module: `uart_cfg_bank`

## Requirements
- R1: After the asynchronous reset, the registers hold their defaults: line control 0x1D, divisor 0x0001, all other registers 0x00. The prescaler therefore reports divide-by-1, and the enhanced and tuning enables are both clear.
- R2: When line-control bit 7 is 1, address 0 reaches the divisor low byte and address 1 reaches the divisor high byte. When bit 7 is 0, address 1 reaches the interrupt-enable register and address 0 reads as zero. The line-control bits map to the outputs as follows: [1:0] word length, [2] two stop bits, [3] parity enable, [4] even parity, [5] forced parity, [6] break.
- R3: Only while line control equals 0xBF does address 2 reach the enhanced feature register, for both reads and writes. In that mode a write to address 2 leaves the FIFO-control shadow unchanged. Once line control is given any other value, address 2 is the FIFO-control register again.
- R4: While enhanced-feature bit 4 is 0, a write to modem control (address 4) updates only bits 0, 1 and 3. Bits 2 and 7:4 keep their previous value. While bit 4 is 1, all eight bits are written.
- R5: While enhanced-feature bit 4 is 0, a write to FIFO control leaves the transmit trigger field (bits 5:4) unchanged. All other stored FIFO-control fields still update.
- R6: Address 6 reaches the flow-threshold register and address 7 reaches the trigger-level register only while enhanced-feature bit 4 and modem-control bit 2 are both 1. Otherwise address 7 is a scratch register, and address 6 reads as zero and ignores writes.
- R7: FIFO control is write-only. Its bit 0 (FIFO enable), bit 3 (DMA mode), bits 5:4 (transmit trigger) and bits 7:6 (receive trigger) are kept in a shadow that drives the outputs. Reading address 2 outside the 0xBF mode returns zero.
- R8: A FIFO-control write with bit 1 set makes the receive-flush output high for exactly the one cycle after the write edge. A write with bit 2 set does the same for the transmit-flush output. These two bits are not stored.
- R9: Modem-control bit 7 selects the baud prescaler: 1 means divide-by-4 and 0 means divide-by-1.
- R10: A synchronous soft-reset input returns every register to its R1 default in one cycle. It takes priority over a write in the same cycle, and it clears any pending flush pulse.
- R11: Reads have no side effects. While the read strobe is low, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swReset | input | 1 | Synchronous soft reset to defaults |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational, zero when rdEn is low |
| divisor | output | 16 | Baud divisor |
| wordLen | output | 2 | Word length code |
| twoStop | output | 1 | Two stop bits |
| parityEn | output | 1 | Parity enable |
| parityEven | output | 1 | Even parity select |
| parityForce | output | 1 | Forced parity |
| breakOn | output | 1 | Break condition |
| irqEnable | output | 8 | Interrupt-enable register |
| fifoEnable | output | 1 | FIFO enable (shadow) |
| dmaMode | output | 1 | DMA mode (shadow) |
| rxTrigger | output | 2 | Receive trigger code (shadow) |
| txTrigger | output | 2 | Transmit trigger code (shadow) |
| txFlush | output | 1 | One-cycle transmit FIFO flush |
| rxFlush | output | 1 | One-cycle receive FIFO flush |
| dtrOut | output | 1 | Modem-control bit 0 |
| rtsOut | output | 1 | Modem-control bit 1 |
| loopback | output | 1 | Modem-control bit 4 |
| prescaleDiv4 | output | 1 | Baud prescaler divide-by-4 |
| enhancedOn | output | 1 | Enhanced-function enable |
| tuningOn | output | 1 | Modem-control tuning-register enable |
| autoRts | output | 1 | Enhanced feature bit 6 |
| autoCts | output | 1 | Enhanced feature bit 7 |
| haltLevel | output | 4 | Flow-threshold halt level |
| resumeLevel | output | 4 | Flow-threshold resume level |
| txTlrLevel | output | 4 | Transmit trigger-level field |
| rxTlrLevel | output | 4 | Receive trigger-level field |

## Verification
The assertions assume two things about the inputs. First, rstN is asserted once at start-up, before any strobe. Second, wrEn, rdEn, addr and wrData are stable around the sampling edge.

The write-gating checks compare each register with its value one cycle earlier. They rely on soft reset being the only way, other than a write, to change a register, so they are disabled for the cycle that follows a soft reset.

The stimulus changes inputs only on the falling clock edge and holds each strobe for exactly one cycle. It moves through the line-control banking states in the order a driver uses: divisor mode, then the 0xBF mode, then normal mode. A read is never issued in the same cycle as a write.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_LO    = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_HI    = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_FIFO  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_LINE  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_MODEM = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_FLOW  = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_TRIG  = 3'd7;

  localparam int ENH_BIT     = 4;
  localparam int TUNE_BIT    = 2;
  localparam int PRESC_BIT   = 7;
  localparam int DLAB_BIT    = 7;
  localparam int RXFLUSH_BIT = 1;
  localparam int TXFLUSH_BIT = 2;

  // modem-control bits writable without the enhanced enable
  localparam logic [DATA_W-1:0] MODEM_FREE = 8'h0B;

  typedef struct packed {
    logic divLo;
    logic divHi;
    logic irq;
    logic fifo;
    logic line;
    logic modem;
    logic feat;
    logic flow;
    logic trig;
    logic scratch;
  } wrStrobe_t;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DIVLO, SEL_DIVHI, SEL_IRQ, SEL_LINE,
    SEL_MODEM, SEL_FEAT, SEL_FLOW, SEL_TRIG, SEL_SCRATCH
  } rdSel_t;
endpackage

// File: rtl/uart_cfg_decode.sv
module uart_cfg_decode
  import uart_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] LINE_MAGIC = 8'hBF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] lineQ,
  input  logic              enhOn,
  input  logic              tuneOn,
  output wrStrobe_t         wrS,
  output rdSel_t            rdSel
);
  logic featMode;
  logic dlab;
  logic tuneOk;

  assign featMode = (lineQ == LINE_MAGIC);
  assign dlab     = lineQ[DLAB_BIT];
  assign tuneOk   = enhOn && tuneOn;

  always_comb begin
    wrS   = '0;
    rdSel = SEL_NONE;
    unique case (addr)
      ADR_LO: begin
        wrS.divLo = wrEn && dlab;
        if (dlab) rdSel = SEL_DIVLO;
      end
      ADR_HI: begin
        wrS.divHi = wrEn && dlab;
        wrS.irq   = wrEn && !dlab;
        rdSel     = dlab ? SEL_DIVHI : SEL_IRQ;
      end
      ADR_FIFO: begin
        wrS.feat = wrEn && featMode;
        wrS.fifo = wrEn && !featMode;
        if (featMode) rdSel = SEL_FEAT;
      end
      ADR_LINE: begin
        wrS.line = wrEn;
        rdSel    = SEL_LINE;
      end
      ADR_MODEM: begin
        wrS.modem = wrEn;
        rdSel     = SEL_MODEM;
      end
      ADR_FLOW: begin
        wrS.flow = wrEn && tuneOk;
        if (tuneOk) rdSel = SEL_FLOW;
      end
      ADR_TRIG: begin
        wrS.trig    = wrEn && tuneOk;
        wrS.scratch = wrEn && !tuneOk;
        rdSel       = tuneOk ? SEL_TRIG : SEL_SCRATCH;
      end
      default: rdSel = SEL_NONE;
    endcase
    if (!rdEn) rdSel = SEL_NONE;
  end

  p_one_target_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrS));

  p_tune_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrS.flow || wrS.trig) |-> (enhOn && tuneOn));
endmodule

// File: rtl/uart_cfg_store.sv
module uart_cfg_store
  import uart_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] LINE_MAGIC = 8'hBF,
  parameter logic [DATA_W-1:0] LINE_RESET = 8'h1D,
  parameter logic [2*DATA_W-1:0] DIV_RESET = 16'h0001
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                swReset,
  input  logic [DATA_W-1:0]   wrData,
  input  wrStrobe_t           wrS,
  input  rdSel_t              rdSel,
  output logic [DATA_W-1:0]   rdData,
  output logic [DATA_W-1:0]   lineQ,
  output logic [DATA_W-1:0]   featQ,
  output logic [DATA_W-1:0]   modemQ,
  output logic [DATA_W-1:0]   fifoQ,
  output logic [DATA_W-1:0]   irqQ,
  output logic [DATA_W-1:0]   flowQ,
  output logic [DATA_W-1:0]   trigQ,
  output logic [2*DATA_W-1:0] divQ,
  output logic                txFlushQ,
  output logic                rxFlushQ
);
  logic [DATA_W-1:0] scratchQ;
  logic [DATA_W-1:0] modemNext;
  logic [DATA_W-1:0] fifoNext;
  logic              enh;

  assign enh = featQ[ENH_BIT];

  // per-bit merge of modem-control write, gated bits held while enhanced is off
  for (genvar i = 0; i < DATA_W; i++) begin : g_modemMerge
    if (MODEM_FREE[i]) begin : g_free
      assign modemNext[i] = wrData[i];
    end else begin : g_gated
      assign modemNext[i] = enh ? wrData[i] : modemQ[i];
    end
  end

  // flush bits are not stored in the shadow
  assign fifoNext = {wrData[7:6], enh ? wrData[5:4] : fifoQ[5:4],
                     wrData[3], 2'b00, wrData[0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ    <= LINE_RESET;
      divQ     <= DIV_RESET;
      featQ    <= '0;
      modemQ   <= '0;
      fifoQ    <= '0;
      irqQ     <= '0;
      flowQ    <= '0;
      trigQ    <= '0;
      scratchQ <= '0;
      txFlushQ <= 1'b0;
      rxFlushQ <= 1'b0;
    end else if (swReset) begin
      lineQ    <= LINE_RESET;
      divQ     <= DIV_RESET;
      featQ    <= '0;
      modemQ   <= '0;
      fifoQ    <= '0;
      irqQ     <= '0;
      flowQ    <= '0;
      trigQ    <= '0;
      scratchQ <= '0;
      txFlushQ <= 1'b0;
      rxFlushQ <= 1'b0;
    end else begin
      if (wrS.divLo)   divQ[DATA_W-1:0]        <= wrData;
      if (wrS.divHi)   divQ[2*DATA_W-1:DATA_W] <= wrData;
      if (wrS.irq)     irqQ     <= wrData;
      if (wrS.line)    lineQ    <= wrData;
      if (wrS.feat)    featQ    <= wrData;
      if (wrS.modem)   modemQ   <= modemNext;
      if (wrS.fifo)    fifoQ    <= fifoNext;
      if (wrS.flow)    flowQ    <= wrData;
      if (wrS.trig)    trigQ    <= wrData;
      if (wrS.scratch) scratchQ <= wrData;
      txFlushQ <= wrS.fifo && wrData[TXFLUSH_BIT];
      rxFlushQ <= wrS.fifo && wrData[RXFLUSH_BIT];
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_DIVLO:   rdData = divQ[DATA_W-1:0];
      SEL_DIVHI:   rdData = divQ[2*DATA_W-1:DATA_W];
      SEL_IRQ:     rdData = irqQ;
      SEL_LINE:    rdData = lineQ;
      SEL_MODEM:   rdData = modemQ;
      SEL_FEAT:    rdData = featQ;
      SEL_FLOW:    rdData = flowQ;
      SEL_TRIG:    rdData = trigQ;
      SEL_SCRATCH: rdData = scratchQ;
      default:     rdData = '0;
    endcase
  end

  p_modem_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(enh) && !$past(swReset)) |->
      (modemQ[7:4] == $past(modemQ[7:4]) && modemQ[2] == $past(modemQ[2])));

  p_fifo_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(enh) && !$past(swReset)) |-> (fifoQ[5:4] == $past(fifoQ[5:4])));

  p_feat_magic_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(featQ) && !$past(swReset)) |-> ($past(lineQ) == LINE_MAGIC));

  p_flush_src_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txFlushQ || rxFlushQ) |-> $past(wrS.fifo));

  p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(swReset) |-> (featQ == '0 && modemQ == '0 && lineQ == LINE_RESET
                        && !txFlushQ && !rxFlushQ));
endmodule

// File: rtl/uart_cfg_bank.sv
module uart_cfg_bank
  import uart_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] LINE_MAGIC = 8'hBF,
  parameter logic [DATA_W-1:0] LINE_RESET = 8'h1D,
  parameter logic [2*DATA_W-1:0] DIV_RESET = 16'h0001
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                swReset,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [2*DATA_W-1:0] divisor,
  output logic [1:0]          wordLen,
  output logic                twoStop,
  output logic                parityEn,
  output logic                parityEven,
  output logic                parityForce,
  output logic                breakOn,
  output logic [DATA_W-1:0]   irqEnable,
  output logic                fifoEnable,
  output logic                dmaMode,
  output logic [1:0]          rxTrigger,
  output logic [1:0]          txTrigger,
  output logic                txFlush,
  output logic                rxFlush,
  output logic                dtrOut,
  output logic                rtsOut,
  output logic                loopback,
  output logic                prescaleDiv4,
  output logic                enhancedOn,
  output logic                tuningOn,
  output logic                autoRts,
  output logic                autoCts,
  output logic [3:0]          haltLevel,
  output logic [3:0]          resumeLevel,
  output logic [3:0]          txTlrLevel,
  output logic [3:0]          rxTlrLevel
);
  wrStrobe_t         wrS;
  rdSel_t            rdSel;
  logic [DATA_W-1:0] lineQ, featQ, modemQ, fifoQ, flowQ, trigQ;

  uart_cfg_decode #(.LINE_MAGIC(LINE_MAGIC)) u_decode (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .lineQ  (lineQ),
    .enhOn  (featQ[ENH_BIT]),
    .tuneOn (modemQ[TUNE_BIT]),
    .wrS    (wrS),
    .rdSel  (rdSel)
  );

  uart_cfg_store #(
    .LINE_MAGIC (LINE_MAGIC),
    .LINE_RESET (LINE_RESET),
    .DIV_RESET  (DIV_RESET)
  ) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .swReset  (swReset),
    .wrData   (wrData),
    .wrS      (wrS),
    .rdSel    (rdSel),
    .rdData   (rdData),
    .lineQ    (lineQ),
    .featQ    (featQ),
    .modemQ   (modemQ),
    .fifoQ    (fifoQ),
    .irqQ     (irqEnable),
    .flowQ    (flowQ),
    .trigQ    (trigQ),
    .divQ     (divisor),
    .txFlushQ (txFlush),
    .rxFlushQ (rxFlush)
  );

  assign wordLen      = lineQ[1:0];
  assign twoStop      = lineQ[2];
  assign parityEn     = lineQ[3];
  assign parityEven   = lineQ[4];
  assign parityForce  = lineQ[5];
  assign breakOn      = lineQ[6];
  assign fifoEnable   = fifoQ[0];
  assign dmaMode      = fifoQ[3];
  assign txTrigger    = fifoQ[5:4];
  assign rxTrigger    = fifoQ[7:6];
  assign dtrOut       = modemQ[0];
  assign rtsOut       = modemQ[1];
  assign loopback     = modemQ[4];
  assign prescaleDiv4 = modemQ[PRESC_BIT];
  assign enhancedOn   = featQ[ENH_BIT];
  assign tuningOn     = modemQ[TUNE_BIT];
  assign autoRts      = featQ[6];
  assign autoCts      = featQ[7];
  assign haltLevel    = flowQ[3:0];
  assign resumeLevel  = flowQ[7:4];
  assign txTlrLevel   = trigQ[3:0];
  assign rxTlrLevel   = trigQ[7:4];

  p_idle_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> (rdData == '0));
endmodule

// File: tb/uart_cfg_bank_bench.sv
module uart_cfg_bank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swReset = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [15:0] divisor;
  logic [1:0]  wordLen, rxTrigger, txTrigger;
  logic        twoStop, parityEn, parityEven, parityForce, breakOn;
  logic [7:0]  irqEnable;
  logic        fifoEnable, dmaMode, txFlush, rxFlush, dtrOut, rtsOut, loopback;
  logic        prescaleDiv4, enhancedOn, tuningOn, autoRts, autoCts;
  logic [3:0]  haltLevel, resumeLevel, txTlrLevel, rxTlrLevel;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  uart_cfg_bank u_uart_cfg_bank (
    .clk(clk), .rstN(rstN), .swReset(swReset), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .divisor(divisor),
    .wordLen(wordLen), .twoStop(twoStop), .parityEn(parityEn),
    .parityEven(parityEven), .parityForce(parityForce), .breakOn(breakOn),
    .irqEnable(irqEnable), .fifoEnable(fifoEnable), .dmaMode(dmaMode),
    .rxTrigger(rxTrigger), .txTrigger(txTrigger), .txFlush(txFlush),
    .rxFlush(rxFlush), .dtrOut(dtrOut), .rtsOut(rtsOut), .loopback(loopback),
    .prescaleDiv4(prescaleDiv4), .enhancedOn(enhancedOn), .tuningOn(tuningOn),
    .autoRts(autoRts), .autoCts(autoCts), .haltLevel(haltLevel),
    .resumeLevel(resumeLevel), .txTlrLevel(txTlrLevel), .rxTlrLevel(rxTlrLevel)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    rdEn = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 divisor", divisor, 16'h0001);
    check("R1 wordLen", wordLen, 2'b01);
    check("R1 parity fields", {parityForce, parityEven, parityEn, twoStop}, 4'b0111);
    check("R1 prescale", prescaleDiv4, 1'b0);
    check("R1 enables", {enhancedOn, tuningOn}, 2'b00);
    rd(3'd3, d);
    check("R1 line readback", d, 8'h1D);
  endtask

  task automatic t_divisor();
    logic [7:0] d;
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    check("R2 divisor", divisor, 16'h1234);
    rd(3'd0, d);
    check("R2 divisor low read", d, 8'h34);
    check("R2 irq untouched", irqEnable, 8'h00);
    wr(3'd3, 8'h03);
    check("R2 line fields", {breakOn, wordLen}, 3'b011);
    wr(3'd1, 8'h05);
    check("R2 irq write", irqEnable, 8'h05);
    check("R2 divisor kept", divisor, 16'h1234);
    rd(3'd0, d);
    check("R2 addr0 normal read", d, 8'h00);
  endtask

  task automatic t_gate_off();
    logic [7:0] d;
    wr(3'd4, 8'hF7);
    rd(3'd4, d);
    check("R4 modem gated write", d, 8'h03);
    check("R9 prescale still div1", prescaleDiv4, 1'b0);
    check("R4 dtr rts", {rtsOut, dtrOut}, 2'b11);
    wr(3'd2, 8'h31);
    check("R5 tx trigger held", txTrigger, 2'b00);
    check("R7 fifo enable shadow", fifoEnable, 1'b1);
    rd(3'd2, d);
    check("R7 fifo read zero", d, 8'h00);
  endtask

  task automatic t_tune_blocked();
    logic [7:0] d;
    wr(3'd7, 8'h5A);
    rd(3'd7, d);
    check("R6 scratch when blocked", d, 8'h5A);
    check("R6 trig untouched", {rxTlrLevel, txTlrLevel}, 8'h00);
    wr(3'd6, 8'h99);
    check("R6 flow untouched", {resumeLevel, haltLevel}, 8'h00);
    rd(3'd6, d);
    check("R6 addr6 read zero", d, 8'h00);
  endtask

  task automatic t_feature();
    logic [7:0] d;
    wr(3'd3, 8'hBF);
    wr(3'd2, 8'hD0);
    rd(3'd2, d);
    check("R3 feature readback", d, 8'hD0);
    check("R3 enhanced on", enhancedOn, 1'b1);
    check("R3 auto flow bits", {autoCts, autoRts}, 2'b11);
    check("R3 fifo shadow untouched", {rxTrigger, txTrigger, fifoEnable}, 5'b00001);
    wr(3'd3, 8'h03);
    rd(3'd2, d);
    check("R3 normal decode restored", d, 8'h00);
    check("R3 feature kept", enhancedOn, 1'b1);
  endtask

  task automatic t_gate_on();
    logic [7:0] d;
    wr(3'd4, 8'h84);
    check("R9 prescale div4", prescaleDiv4, 1'b1);
    check("R4 tuning bit written", tuningOn, 1'b1);
    wr(3'd2, 8'hF1);
    check("R5 tx trigger written", txTrigger, 2'b11);
    check("R7 rx trigger", rxTrigger, 2'b11);
    wr(3'd6, 8'h4C);
    check("R6 flow levels", {resumeLevel, haltLevel}, 8'h4C);
    rd(3'd6, d);
    check("R6 flow readback", d, 8'h4C);
    wr(3'd7, 8'h21);
    rd(3'd7, d);
    check("R6 trig readback", d, 8'h21);
    wr(3'd4, 8'h80);
    rd(3'd7, d);
    check("R6 scratch returns", d, 8'h5A);
    check("R6 trig output kept", {rxTlrLevel, txTlrLevel}, 8'h21);
  endtask

  task automatic t_flush();
    wr(3'd2, 8'h07);
    check("R8 both flush pulses", {txFlush, rxFlush}, 2'b11);
    check("R8 triggers rewritten", {rxTrigger, txTrigger}, 4'b0000);
    @(negedge clk);
    check("R8 pulses one cycle", {txFlush, rxFlush}, 2'b00);
    wr(3'd2, 8'h03);
    check("R8 rx only", {txFlush, rxFlush}, 2'b01);
    check("R7 dma clear", dmaMode, 1'b0);
    @(negedge clk);
    check("R8 rx pulse ends", rxFlush, 1'b0);
  endtask

  task automatic t_read_quiet();
    logic [7:0] d;
    @(negedge clk);
    addr = 3'd3;
    #1 check("R11 idle read zero", rdData, 8'h00);
    rd(3'd2, d);
    rd(3'd2, d);
    @(negedge clk);
    check("R11 read no flush", {txFlush, rxFlush}, 2'b00);
    check("R11 read keeps fifo", fifoEnable, 1'b1);
  endtask

  task automatic t_swreset();
    logic [7:0] d;
    @(negedge clk);
    swReset = 1'b1; wrEn = 1'b1; addr = 3'd3; wrData = 8'h55;
    @(negedge clk);
    swReset = 1'b0; wrEn = 1'b0;
    rd(3'd3, d);
    check("R10 line default beats write", d, 8'h1D);
    check("R10 enables cleared", {enhancedOn, tuningOn, prescaleDiv4}, 3'b000);
    check("R10 divisor default", divisor, 16'h0001);
    check("R10 fifo shadow cleared", {rxTrigger, txTrigger, fifoEnable}, 5'b0);
    wr(3'd6, 8'hAB);
    check("R10 tuning blocked again", haltLevel, 4'h0);
    rd(3'd7, d);
    check("R10 scratch default", d, 8'h00);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_divisor();
    t_gate_off();
    t_tune_blocked();
    t_feature();
    t_gate_on();
    t_flush();
    t_read_quiet();
    t_swreset();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
    finish_run();
  end
endmodule